// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM. The bus can alternate between reads and writes on every clock with no idle cycle between them. Address, chip selects, write strobe and byte-lane enables are captured at a rising clock edge. A write's data is taken from the bus the same number of cycles after its command as a read's data would be driven. Because of this, every command owns exactly one bus cycle, whichever direction it uses.

A static mode pin chooses between two latencies. In pipelined mode, read data passes through an output register. In flow mode, read data comes straight from the array and appears one cycle earlier. The write data delay follows the same choice. Writes commit to the array at the edge where their data arrives. In pipelined mode a read can be issued before an earlier write's data has arrived. That read picks up the in-flight data lane by lane.

The bidirectional data bus is split into an input, an output and an output-enable. A clock-enable input stalls the whole block. An asynchronous output-enable input can silence the drivers at any time.

Top module: `zt_sram`

## Requirements
- R1: The part is selected only when ce1_n is 0, ce2 is 1 and ce3_n is 0. A read or write presented while any of the three is inactive does nothing: the bus stays released in that command's slot and the array keeps its contents.
- R2: A read is accepted at an active edge (cke_n 0) when the part is selected, adv_ld_n is 0 and we_n is 1. With we_n 0 it is a write. With adv_ld_n 1 no access starts.
- R3: With flow_n at 1 (pipelined, the default position), read data is driven (dq_oe 1) during the cycle that follows the next active edge after the command edge.
- R4: With flow_n at 0 (flow mode), read data is driven during the cycle directly after the command edge.
- R5: Write data is sampled from dq_in at the second active edge after the command in pipelined mode, or at the first active edge after it in flow mode. dq_oe stays 0 throughout that data cycle.
- R6: Byte lane i occupies bits [9i+8:9i]. It is written only when bw_n[i] is 0. A write with all four bw_n bits at 1 leaves the array unchanged.
- R7: An edge with cke_n at 1 has no effect. Pending reads, pending writes and the driven output all hold until the next edge with cke_n at 0.
- R8: oe_n at 1 forces dq_oe to 0 at once, without waiting for a clock. oe_n at 0 only lets through a read slot that is already due.
- R9: dq_out is all zeros whenever dq_oe is 0. The synchronous active-high rst discards every pending access, so nothing is driven after it.
- R10: In pipelined mode, a read issued right after a write to the same address, before that write's data has arrived, returns the write's enabled lanes merged with the stored contents of the other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the access pipeline |
| flow_n | input | 1 | Static mode: 1 pipelined, 0 flow |
| cke_n | input | 1 | Clock enable, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| adv_ld_n | input | 1 | Access start, active low |
| addr | input | ADDR_W (6) | Word address |
| bw_n | input | 4 | Byte-lane write enables, active low |
| dq_in | input | 36 | Write data from the bus |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | 36 | Read data onto the bus |
| dq_oe | output | 1 | Bus driver enable |

## Verification
Each command owns one bus slot. In pipelined mode the slot is the cycle after the second active edge counted from the command edge; in flow mode it is the cycle after the command edge. The bench issues one command per cycle and, for each cycle, computes which earlier command owns the slot. It drives write data for that command and samples read data at the falling edge in the middle of the slot. When cke_n is held high, the expected slot moves later by one cycle per frozen edge, and the checks are placed to match. The oe_n checks are taken one nanosecond after the pin changes, with no clock edge in between.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/1ps
package zt_sram_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DATA_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [LANES-1:0] lane_en;
    } cmd_t;

    localparam cmd_t CMD_NONE = '{op: OP_IDLE, lane_en: '0};

    // Replace the selected lanes of base with those of upd.
    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] base,
        input logic [DATA_W-1:0] upd,
        input logic [LANES-1:0]  sel
    );
        logic [DATA_W-1:0] r;
        r = base;
        for (int i = 0; i < LANES; i++) begin
            if (sel[i]) r[i*LANE_W +: LANE_W] = upd[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/zt_cmd_decode.sv
`timescale 1ns/1ps
module zt_cmd_decode
    import zt_sram_pkg::*;
(
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             we_n,
    input  logic             adv_ld_n,
    input  logic [LANES-1:0] bw_n,
    output cmd_t             cmd
);

    logic chip_on;

    always_comb begin
        chip_on = !ce1_n && ce2 && !ce3_n;
        cmd     = CMD_NONE;
        if (chip_on && !adv_ld_n) begin
            if (we_n) begin
                cmd.op = OP_READ;
            end else begin
                cmd.op      = OP_WRITE;
                cmd.lane_en = ~bw_n;
            end
        end
    end

endmodule

// File: rtl/zt_cmd_pipe.sv
`timescale 1ns/1ps
module zt_cmd_pipe
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  cmd_t              cmd_in,
    input  logic [ADDR_W-1:0] addr_in,
    output cmd_t              stg_cmd  [STAGES],
    output logic [ADDR_W-1:0] stg_addr [STAGES]
);

    cmd_t              nxt_cmd  [STAGES];
    logic [ADDR_W-1:0] nxt_addr [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_head
            assign nxt_cmd[s]  = cmd_in;
            assign nxt_addr[s] = addr_in;
        end else begin : g_tail
            assign nxt_cmd[s]  = stg_cmd[s-1];
            assign nxt_addr[s] = stg_addr[s-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stg_cmd[s]  <= CMD_NONE;
                stg_addr[s] <= '0;
            end else if (step) begin
                stg_cmd[s]  <= nxt_cmd[s];
                stg_addr[s] <= nxt_addr[s];
            end
        end
    end

    // R7: a stalled edge leaves every stage untouched
    a_r7_stall_holds: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(stg_cmd[0]) && $stable(stg_addr[0]) &&
                   $stable(stg_cmd[STAGES-1]) && $stable(stg_addr[STAGES-1])));

endmodule

// File: rtl/zt_lane_array.sv
`timescale 1ns/1ps
module zt_lane_array
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[l]) mem[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
        end

        assign rd_data[l*LANE_W +: LANE_W] = mem[rd_addr];
    end

endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flow_n,
    input  logic              cke_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              we_n,
    input  logic              adv_ld_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  bw_n,
    input  logic [DATA_W-1:0] dq_in,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    localparam int STAGES = 2;
    localparam int LAST   = STAGES - 1;

    logic              step;
    cmd_t              dec_cmd;
    cmd_t              stg_cmd  [STAGES];
    logic [ADDR_W-1:0] stg_addr [STAGES];
    cmd_t              slot_cmd;
    logic [ADDR_W-1:0] slot_addr;
    logic              wr_en;
    logic [DATA_W-1:0] arr_rd;
    logic              fwd_hit;
    logic [DATA_W-1:0] load_data;
    logic [DATA_W-1:0] out_q;
    logic              drive_vld;
    logic [DATA_W-1:0] drive_data;

    assign step = !cke_n;

    zt_cmd_decode u_dec (
        .ce1_n    (ce1_n),
        .ce2      (ce2),
        .ce3_n    (ce3_n),
        .we_n     (we_n),
        .adv_ld_n (adv_ld_n),
        .bw_n     (bw_n),
        .cmd      (dec_cmd)
    );

    zt_cmd_pipe #(.ADDR_W(ADDR_W), .STAGES(STAGES)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .cmd_in   (dec_cmd),
        .addr_in  (addr),
        .stg_cmd  (stg_cmd),
        .stg_addr (stg_addr)
    );

    // The stage that owns the bus this cycle depends on the mode.
    always_comb begin
        slot_cmd  = flow_n ? stg_cmd[LAST]  : stg_cmd[0];
        slot_addr = flow_n ? stg_addr[LAST] : stg_addr[0];
    end

    assign wr_en = step && (slot_cmd.op == OP_WRITE);

    zt_lane_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_addr  (slot_addr),
        .wr_lanes (slot_cmd.lane_en),
        .wr_data  (dq_in),
        .rd_addr  (stg_addr[0]),
        .rd_data  (arr_rd)
    );

    // Pipelined read loading its register while the preceding write's data
    // is on the bus this very edge.
    always_comb begin
        fwd_hit   = (stg_cmd[LAST].op == OP_WRITE) && (stg_addr[LAST] == stg_addr[0]);
        load_data = fwd_hit ? lane_merge(arr_rd, dq_in, stg_cmd[LAST].lane_en) : arr_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (step && stg_cmd[0].op == OP_READ) begin
            out_q <= load_data;
        end
    end

    always_comb begin
        drive_vld  = (slot_cmd.op == OP_READ);
        drive_data = flow_n ? out_q : arr_rd;
        dq_oe      = drive_vld && !oe_n;
        dq_out     = dq_oe ? drive_data : '0;
    end

    // R1: a deselected edge queues nothing
    a_r1_desel_empty: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && (ce1_n || !ce2 || ce3_n)) |=> (stg_cmd[0].op == OP_IDLE));

    // R2: a well-formed read at the pins enters the first stage
    a_r2_read_taken: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && !ce1_n && ce2 && !ce3_n && we_n && !adv_ld_n)
        |=> (stg_cmd[0].op == OP_READ));

    // R3: pipelined read reaches the bus one active edge after capture
    a_r3_pipe_drive: assert property (@(posedge clk) disable iff (rst)
        (flow_n && $past(flow_n) && !$past(rst) && $past(step) &&
         $past(stg_cmd[0].op == OP_READ) && !oe_n) |-> dq_oe);

    // R5: no driver contention during a write data cycle
    a_r5_write_slot_quiet: assert property (@(posedge clk) disable iff (rst)
        (slot_cmd.op == OP_WRITE) |-> !dq_oe);

    // R8: output enable high always releases the bus
    a_r8_oe_release: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_oe);

    // R9: released bus carries zeros
    a_r9_zero_idle: assert property (@(posedge clk) disable iff (rst)
        !dq_oe |-> (dq_out == '0));

endmodule

// File: tb/zt_sram_tb.sv
`timescale 1ns/1ps
module zt_sram_tb_top;
    import zt_sram_pkg::*;

    localparam int AW    = 6;
    localparam int TBL_N = 17;
    localparam int ENT_W = 3 + AW + LANES + 2 * DATA_W;
    localparam logic [DATA_W-1:0] JUNK = 36'h5A5A5A5A5;

    // entry: op, addr, bw_n, data, expected read value
    // op: 0 ce1_n high, 1 read, 2 write, 3 read with ce2 low,
    //     4 write with ce3_n high, 5 read with adv_ld_n high
    localparam logic [ENT_W-1:0] TBL [TBL_N] = '{
        {3'd2, 6'd1, 4'b0000, 36'h123456789, 36'h000000000},
        {3'd2, 6'd2, 4'b0000, 36'hABCDEF012, 36'h000000000},
        {3'd1, 6'd1, 4'b1111, 36'h000000000, 36'h123456789},
        {3'd2, 6'd1, 4'b1110, 36'h000000155, 36'h000000000},
        {3'd1, 6'd1, 4'b1111, 36'h000000000, 36'h123456755},
        {3'd1, 6'd2, 4'b1111, 36'h000000000, 36'hABCDEF012},
        {3'd2, 6'd2, 4'b1111, 36'hFFFFFFFFF, 36'h000000000},
        {3'd1, 6'd2, 4'b1111, 36'h000000000, 36'hABCDEF012},
        {3'd2, 6'd3, 4'b0000, 36'h000000000, 36'h000000000},
        {3'd2, 6'd3, 4'b0101, 36'hFFFFFFFFF, 36'h000000000},
        {3'd1, 6'd3, 4'b1111, 36'h000000000, 36'hFF803FE00},
        {3'd0, 6'd0, 4'b1111, 36'h000000000, 36'h000000000},
        {3'd3, 6'd3, 4'b1111, 36'h000000000, 36'h000000000},
        {3'd4, 6'd1, 4'b0000, 36'h000000000, 36'h000000000},
        {3'd1, 6'd1, 4'b1111, 36'h000000000, 36'h123456755},
        {3'd5, 6'd1, 4'b1111, 36'h000000000, 36'h000000000},
        {3'd1, 6'd2, 4'b1111, 36'h000000000, 36'hABCDEF012}
    };

    logic              clk = 1'b0;
    logic              rst, flow_n, cke_n, ce1_n, ce2, ce3_n, we_n, adv_ld_n, oe_n;
    logic [AW-1:0]     addr;
    logic [LANES-1:0]  bw_n;
    logic [DATA_W-1:0] dq_in, dq_out;
    logic              dq_oe;
    int                n_cmp = 0;
    int                n_bad = 0;
    bit                done  = 1'b0;

    always #4 clk = ~clk;

    zt_sram #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .flow_n(flow_n), .cke_n(cke_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n),
        .adv_ld_n(adv_ld_n), .addr(addr), .bw_n(bw_n), .dq_in(dq_in),
        .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic chk(input string tag, input logic exp_oe, input logic [DATA_W-1:0] exp_d);
        n_cmp++;
        if (dq_oe !== exp_oe || dq_out !== exp_d) begin
            n_bad++;
            $display("FAIL %s: actual oe=%0b data=%h, expected oe=%0b data=%h",
                     tag, dq_oe, dq_out, exp_oe, exp_d);
        end
    endtask

    task automatic put_cmd(input int op, input logic [AW-1:0] a, input logic [LANES-1:0] bw);
        ce1_n    = (op == 0);
        ce2      = (op != 3);
        ce3_n    = (op == 4);
        adv_ld_n = (op == 5);
        we_n     = !(op == 2 || op == 4);
        addr     = a;
        bw_n     = bw;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        put_cmd(0, '0, '1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic string tag_of(input int i, input bit flow);
        case (i)
            3, 7, 9:    return "R6";
            4, 10:      return "R10";
            12, 13, 14: return "R1";
            15:         return "R2";
            0, 1, 6, 8: return "R5";
            default:    return flow ? "R4" : "R3";
        endcase
    endfunction

    // One command per cycle; slot of command j is sampled at negedge j+lat+1.
    task automatic run_table(input bit flow);
        int lat;
        lat = flow ? 0 : 1;
        for (int n = 0; n < TBL_N + 3; n++) begin
            int j;
            logic [ENT_W-1:0] e;
            j = n - lat - 1;
            @(negedge clk);
            dq_in = JUNK;
            if (j >= 0 && j < TBL_N) begin
                e = TBL[j];
                if (e[ENT_W-1 -: 3] == 3'd1)
                    chk(tag_of(j, flow), 1'b1, e[DATA_W-1:0]);
                else
                    chk(tag_of(j, flow), 1'b0, '0);
                if (e[ENT_W-1 -: 3] == 3'd2 || e[ENT_W-1 -: 3] == 3'd4)
                    dq_in = e[2*DATA_W-1 -: DATA_W];
            end
            if (n < TBL_N) begin
                e = TBL[n];
                put_cmd(int'(e[ENT_W-1 -: 3]), e[ENT_W-4 -: AW], e[ENT_W-4-AW -: LANES]);
            end else begin
                put_cmd(0, '0, '1);
            end
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual run still going, expected finish");
        summary();
    end

    initial begin
        rst = 1'b1; flow_n = 1'b1; cke_n = 1'b0; oe_n = 1'b0; dq_in = '0;
        put_cmd(0, '0, '1);

        // ---------------- pipelined mode ----------------
        do_reset();
        @(negedge clk); chk("R9", 1'b0, '0);     // R9 reset state
        run_table(1'b0);

        // R7: stall between capture and slot delays the read
        @(negedge clk); put_cmd(1, 6'd2, '1);
        @(negedge clk); put_cmd(0, '0, '1); cke_n = 1'b1;
        @(negedge clk); chk("R7", 1'b0, '0); cke_n = 1'b0;
        @(negedge clk); chk("R7", 1'b1, 36'hABCDEF012); cke_n = 1'b1;
        @(negedge clk); chk("R7", 1'b1, 36'hABCDEF012); cke_n = 1'b0;
        @(negedge clk); chk("R7", 1'b0, '0);

        // R8: asynchronous output enable
        put_cmd(1, 6'd1, '1);
        @(negedge clk); put_cmd(0, '0, '1);
        @(negedge clk); chk("R8", 1'b1, 36'h123456755);
        oe_n = 1'b1; #1; chk("R8", 1'b0, '0);
        oe_n = 1'b0; #1; chk("R8", 1'b1, 36'h123456755);

        // R9: reset drops a read in flight
        @(negedge clk); put_cmd(1, 6'd2, '1);
        @(negedge clk); put_cmd(0, '0, '1); rst = 1'b1;
        @(negedge clk); chk("R9", 1'b0, '0); rst = 1'b0;

        // ---------------- flow mode ----------------
        flow_n = 1'b0;
        do_reset();
        run_table(1'b1);

        // R7: stalled edge must not take write data
        @(negedge clk); put_cmd(2, 6'd5, 4'b0000);
        @(negedge clk); put_cmd(0, '0, '1); cke_n = 1'b1; dq_in = 36'h111111111;
        @(negedge clk); cke_n = 1'b0; dq_in = 36'h2468ACE13;
        @(negedge clk); dq_in = JUNK; put_cmd(1, 6'd5, '1);
        @(negedge clk); chk("R7", 1'b1, 36'h2468ACE13); put_cmd(0, '0, '1);

        @(negedge clk);
        summary();
    end

endmodule